// File: doc/BRIEF.md
# Conflict-Allocating Instruction Cache

This block sits between an instruction sequencer and a program-memory bus that carries both instruction fetches and data operands. Under normal operation an instruction fetch reads program memory directly. When a fetch and a data access need that bus in the same cycle, the data access takes the bus and the fetch stalls. In the next free cycle the instruction is read from memory, handed to the sequencer and written into the cache. From then on, fetches of that address are served by the cache, and the bus stays free for data.

Only conflicting fetches ever take a cache line. A tight loop whose instruction fetches collide with operand reads therefore pays the stall once per conflicting instruction on its first pass, then runs without stalls. The cache has 32 entries in 16 sets of 2 ways. Each set keeps one least-recently-used bit. An invalidate-all input empties the cache in one cycle. A disable input bypasses the cache entirely while keeping the conflict stall.

Top module: `conflict_icache`

## Requirements
- R1: After reset every entry is invalid. A first fetch of any address is never served from the cache.
- R2: A fetch whose address matches a valid entry returns that entry's 48-bit word with `fetch_valid` high in the same cycle, and does not drive `mem_rd_en`. This holds whatever the state of `data_req`.
- R3: A missing fetch with `data_req` low reads memory at `fetch_addr`, returns `mem_rd_data` with `fetch_valid` in the same cycle, and allocates nothing. A repeat of that fetch reads memory again.
- R4: A missing fetch with `data_req` high raises `fetch_stall` and performs no memory read in that cycle. In the next cycle with `data_req` low, the block reads memory at the captured address, delivers the word and writes it into the cache.
- R5: While a stalled fetch is pending, each cycle with `data_req` high keeps `fetch_stall` high with no memory read. During this time the sequencer holds its request and address.
- R6: `mem_rd_en` is never high in a cycle in which `data_req` is high.
- R7: Allocation picks the first invalid way of the set, trying way 0 before way 1. If both ways are valid, it replaces the way least recently hit or filled. Each hit or fill makes the other way of that set the next victim.
- R8: `inv_all` clears every valid bit at the next clock edge. A fill completing in the same cycle is dropped. A hit in that cycle is still served.
- R9: While `cache_dis` is high, no fetch hits and no fill takes place, but conflicting fetches still stall as in R4.
- R10: A loop whose fetches all collide with data accesses runs with no stall on its second pass, provided its addresses fit the sets.
- R11: The set index is `fetch_addr[3:0]` and the tag is `fetch_addr[23:4]`. Addresses that differ only in bits 23..4 compete for the same set.
- R12: With `fetch_req` low and no stalled fetch pending, `fetch_valid`, `fetch_stall` and `mem_rd_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Sequencer requests an instruction this cycle |
| fetch_addr | input | 24 | Instruction address |
| fetch_insn | output | 48 | Instruction word, meaningful when `fetch_valid` is high |
| fetch_valid | output | 1 | Instruction delivered this cycle |
| fetch_stall | output | 1 | Fetch is held; sequencer must repeat it |
| data_req | input | 1 | A data access owns the program-memory bus this cycle |
| inv_all | input | 1 | Invalidate every entry |
| cache_dis | input | 1 | Bypass the cache: no hits, no fills |
| mem_rd_en | output | 1 | Instruction read on the program-memory bus |
| mem_rd_addr | output | 24 | Address of that read |
| mem_rd_data | input | 48 | Word returned by memory in the same cycle |

## Verification
The bench builds the block with its default parameters: 24-bit addresses, 48-bit words and 32 entries in 16 two-way sets. Random addresses are drawn from three tags per set. Each set therefore sees more distinct addresses than it has ways, so evictions, replacement choices and re-fills after eviction happen often. Invalidates arrive about once every 64 cycles, so the cache keeps filling from empty. Random `data_req` and `cache_dis` mix conflict stalls, multi-cycle replays, disabled fills and hits.

// File: rtl/sic_pkg.sv
// Shared definitions for the conflict-allocating instruction cache.
// Assumes a fixed two-way organisation; depth and widths are top parameters.
package sic_pkg;
    localparam int unsigned SIC_WAYS  = 2;
    localparam int unsigned SIC_WAY_W = 1;

    typedef enum logic {
        SIC_IDLE   = 1'b0,
        SIC_REPLAY = 1'b1
    } sic_state_e;
endpackage

// File: rtl/sic_way_store.sv
// One way of the cache: a valid bit, a tag and an instruction word per set.
// Reads are combinational at rd_idx. Writes and invalidation take effect at the clock edge.
// Invalidate-all takes precedence over a write in the same cycle.
module sic_way_store #(
    parameter int unsigned SETS   = 16,
    parameter int unsigned TAG_W  = 20,
    parameter int unsigned INSN_W = 48,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [INSN_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [INSN_W-1:0] wr_data,
    input  logic              inv_all,
    output logic [SETS-1:0]   valid_vec
);
    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [INSN_W-1:0] data_q [SETS];

    // Valid bits: cleared by reset or invalidate-all, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and word storage: written on a fill, never reset.
    always_ff @(posedge clk) begin
        if (wr_en && !inv_all) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    // Read port for lookup and for choosing a victim.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_data  = data_q[rd_idx];
    end

    assign valid_vec = valid_q;
endmodule

// File: rtl/sic_lru.sv
// Replacement state: one bit per set that names the next way to replace.
// Assumes two ways; a touch of one way makes the other the next victim.
module sic_lru #(
    parameter int unsigned SETS = 16,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_way,
    input  logic [IDX_W-1:0] look_idx,
    output logic             victim_way
);
    logic [SETS-1:0] next_victim_q;

    // Point the set at the way that was not just used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_victim_q <= '0;
        end else if (touch_en) begin
            next_victim_q[touch_idx] <= ~touch_way;
        end
    end

    assign victim_way = next_victim_q[look_idx];
endmodule

// File: rtl/sic_ctrl.sv
// Fetch control: serves hits, passes plain misses to memory, and parks
// a fetch that collides with a data access until the bus is free.
// Assumes the sequencer holds its request while fetch_stall is high.
// The parked address is captured, so later input changes do not matter.
module sic_ctrl
    import sic_pkg::*;
#(
    parameter int unsigned ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_req,
    input  logic              lookup_hit,
    input  logic              cache_dis,
    input  logic              inv_all,
    output logic              replay,
    output logic [ADDR_W-1:0] pend_addr,
    output logic              fetch_valid,
    output logic              fetch_stall,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              alloc_en,
    output logic              hit_take
);
    sic_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pend_q;
    logic              capture;

    // Per-cycle decisions for the current state.
    always_comb begin
        state_d     = state_q;
        fetch_valid = 1'b0;
        fetch_stall = 1'b0;
        mem_rd_en   = 1'b0;
        alloc_en    = 1'b0;
        hit_take    = 1'b0;
        capture     = 1'b0;
        case (state_q)
            SIC_IDLE: begin
                if (fetch_req) begin
                    if (lookup_hit) begin
                        hit_take    = 1'b1;
                        fetch_valid = 1'b1;
                    end else if (data_req) begin
                        fetch_stall = 1'b1;
                        capture     = 1'b1;
                        state_d     = SIC_REPLAY;
                    end else begin
                        mem_rd_en   = 1'b1;
                        fetch_valid = 1'b1;
                    end
                end
            end
            SIC_REPLAY: begin
                if (data_req) begin
                    fetch_stall = 1'b1;
                end else begin
                    mem_rd_en   = 1'b1;
                    fetch_valid = 1'b1;
                    alloc_en    = !cache_dis && !inv_all;
                    state_d     = SIC_IDLE;
                end
            end
            default: state_d = SIC_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SIC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture the address of a fetch that lost the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (capture) begin
            pend_q <= fetch_addr;
        end
    end

    assign replay      = (state_q == SIC_REPLAY);
    assign pend_addr   = pend_q;
    assign mem_rd_addr = replay ? pend_q : fetch_addr;
endmodule

// File: rtl/conflict_icache.sv
// Top of the conflict-allocating instruction cache: lookup across the ways,
// victim choice, fill path and output selection. Memory answers a read
// in the same cycle it is requested.
module conflict_icache
    import sic_pkg::*;
#(
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned INSN_W  = 48,
    parameter int unsigned ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [INSN_W-1:0] fetch_insn,
    output logic              fetch_valid,
    output logic              fetch_stall,
    input  logic              data_req,
    input  logic              inv_all,
    input  logic              cache_dis,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [INSN_W-1:0] mem_rd_data
);
    localparam int unsigned WAYS  = SIC_WAYS;
    localparam int unsigned SETS  = ENTRIES / WAYS;
    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned TAG_W = ADDR_W - IDX_W;

    logic              replay, alloc_en, hit_take, lookup_hit;
    logic [ADDR_W-1:0] pend_addr, look_addr;
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic [WAYS-1:0]   way_valid, way_hit;
    logic [TAG_W-1:0]  way_tag  [WAYS];
    logic [INSN_W-1:0] way_data [WAYS];
    logic [ENTRIES-1:0] valid_vec;
    logic [INSN_W-1:0] hit_data;
    logic              hit_way, victim_lru, alloc_way;

    // While a fetch is parked, look at its set; otherwise at the live fetch.
    assign look_addr = replay ? pend_addr : fetch_addr;
    assign look_idx  = look_addr[IDX_W-1:0];
    assign look_tag  = look_addr[ADDR_W-1:IDX_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        sic_way_store #(
            .SETS   (SETS),
            .TAG_W  (TAG_W),
            .INSN_W (INSN_W)
        ) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_idx    (look_idx),
            .rd_valid  (way_valid[w]),
            .rd_tag    (way_tag[w]),
            .rd_data   (way_data[w]),
            .wr_en     (alloc_en && (alloc_way == SIC_WAY_W'(w))),
            .wr_idx    (look_idx),
            .wr_tag    (look_tag),
            .wr_data   (mem_rd_data),
            .inv_all   (inv_all),
            .valid_vec (valid_vec[w*SETS +: SETS])
        );
        // Tag match per way, suppressed while the cache is bypassed.
        assign way_hit[w] = way_valid[w] && (way_tag[w] == look_tag) && !cache_dis;
    end

    // Select the word and way index of the matching way.
    always_comb begin
        hit_data = '0;
        hit_way  = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) begin
                hit_data = way_data[w];
                hit_way  = SIC_WAY_W'(w);
            end
        end
    end

    assign lookup_hit = |way_hit;

    // Victim: the first empty way, else the least recently used one.
    always_comb begin
        if (!way_valid[0]) begin
            alloc_way = 1'b0;
        end else if (!way_valid[1]) begin
            alloc_way = 1'b1;
        end else begin
            alloc_way = victim_lru;
        end
    end

    sic_lru #(
        .SETS (SETS)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (hit_take || alloc_en),
        .touch_idx  (look_idx),
        .touch_way  (alloc_en ? alloc_way : hit_way),
        .look_idx   (look_idx),
        .victim_way (victim_lru)
    );

    sic_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .data_req    (data_req),
        .lookup_hit  (lookup_hit),
        .cache_dis   (cache_dis),
        .inv_all     (inv_all),
        .replay      (replay),
        .pend_addr   (pend_addr),
        .fetch_valid (fetch_valid),
        .fetch_stall (fetch_stall),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .alloc_en    (alloc_en),
        .hit_take    (hit_take)
    );

    // A hit returns the stored word; every other delivery comes from memory.
    assign fetch_insn = hit_take ? hit_data : mem_rd_data;
endmodule

// File: rtl/conflict_icache_chk.sv
// Checker for conflict_icache: bus ownership, stall behaviour, bypass and
// invalidation, observed at the ports and at the stores' valid bits.
module conflict_icache_chk #(
    parameter int unsigned ENTRIES = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_req,
    input logic               data_req,
    input logic               inv_all,
    input logic               cache_dis,
    input logic               fetch_valid,
    input logic               fetch_stall,
    input logic               mem_rd_en,
    input logic [ENTRIES-1:0] valid_vec
);
    // The instruction read never shares the bus with a data access.
    assert_bus_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !data_req);

    // A stall only occurs while a data access owns the bus.
    assert_stall_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> (data_req && !mem_rd_en && !fetch_valid));

    // A stalled fetch either stays stalled or completes in the next cycle.
    assert_stall_resolves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> (fetch_stall || (fetch_valid && mem_rd_en)));

    // After invalidate-all no entry remains valid.
    assert_inv_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_vec == '0));

    // A bypassed cache delivers only through a memory read.
    assert_disable_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_dis && fetch_valid) |-> mem_rd_en);

    // An idle sequencer with nothing pending sees no activity.
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_req && !$past(fetch_stall)) |-> (!fetch_valid && !fetch_stall && !mem_rd_en));
endmodule

bind conflict_icache conflict_icache_chk #(
    .ENTRIES (ENTRIES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .data_req    (data_req),
    .inv_all     (inv_all),
    .cache_dis   (cache_dis),
    .fetch_valid (fetch_valid),
    .fetch_stall (fetch_stall),
    .mem_rd_en   (mem_rd_en),
    .valid_vec   (valid_vec)
);

// File: tb/conflict_icache_bench.sv
// Bench for conflict_icache: a reference model in bench functions, directed
// corner cases, then seeded random traffic on a small address pool.
module conflict_icache_bench;
    localparam int AW = 24;
    localparam int IW = 48;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fetch_req, data_req, inv_all, cache_dis;
    logic [AW-1:0] fetch_addr;
    logic [IW-1:0] fetch_insn, mem_rd_data;
    logic          fetch_valid, fetch_stall, mem_rd_en;
    logic [AW-1:0] mem_rd_addr;

    always #5 clk = ~clk;

    conflict_icache u_conflict_icache (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fetch_insn  (fetch_insn),
        .fetch_valid (fetch_valid),
        .fetch_stall (fetch_stall),
        .data_req    (data_req),
        .inv_all     (inv_all),
        .cache_dis   (cache_dis),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data)
    );

    function automatic logic [IW-1:0] mem_word(input logic [AW-1:0] a);
        return {a ^ 24'hC3A511, ~a};
    endfunction

    assign mem_rd_data = mem_word(mem_rd_addr);

    int n_chk = 0;
    int n_bad = 0;
    int stall_cnt = 0;

    // Reference model state
    bit            m_val [NS][2];
    logic [19:0]   m_tag [NS][2];
    logic [IW-1:0] m_dat [NS][2];
    bit            m_lru [NS];
    bit            m_pend;
    logic [AW-1:0] m_paddr;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) m_val[s][w] = 1'b0;
        end
        m_pend = 1'b0;
        m_paddr = '0;
    endtask

    // One cycle: drive, compare against the model, advance the model.
    task automatic step(input bit fr, input logic [AW-1:0] a, input bit dr,
                        input bit iv, input bit ds, input string req);
        bit ev, es, er, hit, alloc;
        int hw, aw;
        logic [IW-1:0] ei;
        logic [AW-1:0] ea;
        logic [3:0] ix;
        @(negedge clk);
        if (m_pend) begin
            fr = 1'b1;
            a  = m_paddr;
        end
        fetch_req = fr; fetch_addr = a; data_req = dr; inv_all = iv; cache_dis = ds;
        #2;
        ev = 0; es = 0; er = 0; hit = 0; alloc = 0; hw = 0; ei = '0; ea = '0;
        ix = a[3:0];
        if (m_pend) begin
            if (dr) es = 1;
            else begin
                er = 1; ea = m_paddr; ev = 1; ei = mem_word(m_paddr);
                alloc = !ds && !iv;
            end
        end else if (fr) begin
            for (int w = 0; w < 2; w++)
                if (!ds && m_val[ix][w] && m_tag[ix][w] == a[23:4]) begin
                    hit = 1; hw = w;
                end
            if (hit) begin
                ev = 1; ei = m_dat[ix][hw];
            end else if (dr) es = 1;
            else begin
                er = 1; ea = a; ev = 1; ei = mem_word(a);
            end
        end
        chk(req, "fetch_valid", 64'(fetch_valid), 64'(ev));
        chk(req, "fetch_stall", 64'(fetch_stall), 64'(es));
        chk(req, "mem_rd_en", 64'(mem_rd_en), 64'(er));
        if (ev) chk(req, "fetch_insn", 64'(fetch_insn), 64'(ei));
        if (er) chk(req, "mem_rd_addr", 64'(mem_rd_addr), 64'(ea));
        if (es) stall_cnt++;
        // advance model
        if (alloc) begin
            aw = !m_val[ix][0] ? 0 : (!m_val[ix][1] ? 1 : int'(m_lru[ix]));
            m_val[ix][aw] = 1; m_tag[ix][aw] = a[23:4]; m_dat[ix][aw] = ei;
            m_lru[ix] = (aw == 0);
        end
        if (hit) m_lru[ix] = (hw == 0);
        if (m_pend) m_pend = dr;
        else if (fr && !hit && dr) begin
            m_pend = 1; m_paddr = a;
        end
        if (iv)
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < 2; w++) m_val[s][w] = 1'b0;
    endtask

    function automatic logic [AW-1:0] mk(input int tag, input int idx);
        return {20'(tag), 4'(idx)};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_500_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; fetch_req = 0; fetch_addr = '0; data_req = 0; inv_all = 0; cache_dis = 0;
        model_reset();
        repeat (3) @(negedge clk);
        #2;
        chk("R1", "reset fetch_valid", 64'(fetch_valid), 64'd0);
        chk("R1", "reset fetch_stall", 64'(fetch_stall), 64'd0);
        chk("R1", "reset mem_rd_en", 64'(mem_rd_en), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: first fetch after reset reads memory, whatever the address
        step(1, mk(7, 2), 0, 0, 0, "R1");
        // R3: plain misses never allocate
        step(1, mk(1, 1), 0, 0, 0, "R3");
        step(1, mk(1, 1), 0, 0, 0, "R3");
        // R12: idle with data traffic
        step(0, mk(0, 0), 1, 0, 0, "R12");
        // R4/R5: conflict, two held cycles, then completion and fill
        step(1, mk(2, 3), 1, 0, 0, "R4");
        step(1, mk(2, 3), 1, 0, 0, "R5");
        step(1, mk(2, 3), 1, 0, 0, "R5");
        step(1, mk(2, 3), 0, 0, 0, "R4");
        // R2: the filled word hits, with and without data traffic
        step(1, mk(2, 3), 1, 0, 0, "R2");
        step(1, mk(2, 3), 0, 0, 0, "R2");
        // R7/R11: three tags competing for set 5
        step(1, mk(1, 5), 1, 0, 0, "R11"); step(1, mk(1, 5), 0, 0, 0, "R11");
        step(1, mk(2, 5), 1, 0, 0, "R7");  step(1, mk(2, 5), 0, 0, 0, "R7");
        step(1, mk(1, 5), 1, 0, 0, "R7");
        step(1, mk(3, 5), 1, 0, 0, "R7");  step(1, mk(3, 5), 0, 0, 0, "R7");
        step(1, mk(2, 5), 1, 0, 0, "R7");
        step(1, mk(2, 5), 0, 0, 0, "R7");
        step(1, mk(1, 5), 1, 0, 0, "R7");
        step(1, mk(1, 5), 0, 0, 0, "R7");
        // R8: hit served in the invalidate cycle, then gone
        step(1, mk(2, 3), 1, 1, 0, "R8");
        step(1, mk(2, 3), 1, 0, 0, "R8");
        step(1, mk(2, 3), 0, 1, 0, "R8");
        step(1, mk(2, 3), 1, 0, 0, "R8");
        step(1, mk(2, 3), 0, 0, 0, "R8");
        // R9: bypass hides the entry and blocks fills
        step(1, mk(2, 3), 0, 0, 1, "R9");
        step(1, mk(4, 9), 1, 0, 1, "R9");
        step(1, mk(4, 9), 0, 0, 1, "R9");
        step(1, mk(4, 9), 1, 0, 0, "R9");
        step(1, mk(4, 9), 0, 0, 0, "R9");
        step(1, mk(2, 3), 1, 0, 0, "R9");

        // R10: conflicting loop, first pass stalls, second pass free
        step(0, mk(0, 0), 0, 1, 0, "R10");
        for (int p = 0; p < 2; p++) begin
            stall_cnt = 0;
            for (int i = 0; i < 10; i++) begin
                step(1, mk(8, i), 1, 0, 0, "R10");
                if (m_pend) begin
                    step(1, mk(8, i), 0, 0, 0, "R10");
                end
            end
            if (p == 1) chk("R10", "second pass stalls", 64'(stall_cnt), 64'd0);
            else chk("R10", "first pass stalls", 64'(stall_cnt), 64'd10);
        end

        // R6: random traffic on three tags per set
        for (int n = 0; n < 4000; n++) begin
            bit rfr, rdr, riv, rds;
            rfr = ($urandom % 10) != 0;
            rdr = ($urandom % 2) != 0;
            riv = ($urandom % 64) == 0;
            rds = ($urandom % 16) == 0;
            step(rfr, mk(int'($urandom % 3), int'($urandom % NS)), rdr, riv, rds, "R6");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule